// File: doc/BRIEF.md
# Periodic Refresh Request Scheduler

This block paces the refresh traffic of a dynamic memory. A timer, loaded from a programmable interval, produces one refresh credit per interval. Credits gather in a small saturating counter of owed refreshes. Each credit is offered to the memory controller as a refresh request on a valid/ready handshake. Every accepted request advances a row pointer that sweeps the whole row space and wraps. This lets a fixed number of row refreshes (4096 by default) be spread evenly over a retention window. For example, a 15.625 us spacing needs an interval of about 2083 clocks at 133 MHz.

The request interface is a single-beat stream with no payload. `req_valid_o` is registered and, once high, stays high until the controller accepts it with `req_ready_i`. The controller may hold `req_ready_i` low for as long as it needs. Intervals that elapse during that time are not lost but owed, up to a fixed limit. `req_ready_i` has no effect while `req_valid_o` is low.

A separate pair of pulses moves the block into and out of a self-refresh state, in which the memory refreshes itself. In that state the timer is frozen, owed credits are discarded and no request is offered. On leaving it the timer restarts from zero and exactly one request is offered at once.

Top module: `refresh_sched`

## Requirements
- R1: During and after reset, `req_valid_o` is 0 and `row_o` is 0.
- R2: Outside self-refresh, one credit is earned every N clocks, where N is `interval_i` (0 is treated as 1). After reset release, `req_valid_o` first rises after the N-th clock edge. If the interval is lowered below the current count, a credit is earned on the next edge.
- R3: Once `req_valid_o` is high, it stays high until a cycle with `req_ready_i` high, unless self-refresh is entered.
- R4: If a credit is earned in the same cycle as an accept, the owed count is unchanged. `req_valid_o` stays high while any credit is owed.
- R5: At most 8 credits can be owed. Credits earned while 8 are owed are dropped, so a long stall followed by continuous `req_ready_i` yields exactly 8 accepts.
- R6: Each accept (`req_valid_o` and `req_ready_i` both high) adds 1 to `row_o` after that edge, wrapping from 4095 to 0. `row_o` does not change otherwise.
- R7: A `sr_enter_i` pulse outside self-refresh drops `req_valid_o` after that edge and clears the owed credits. It also freezes the timer. While in self-refresh, `req_ready_i` has no effect on `row_o`.
- R8: A `sr_exit_i` pulse in self-refresh restarts the timer from zero and sets exactly one owed credit, so `req_valid_o` is high after that edge.
- R9: `sr_enter_i` is ignored while in self-refresh, and `sr_exit_i` is ignored outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_i | input | 12 | Clocks per refresh credit |
| req_valid_o | output | 1 | Refresh request offered |
| req_ready_i | input | 1 | Controller accepts the request |
| sr_enter_i | input | 1 | Pulse: enter self-refresh |
| sr_exit_i | input | 1 | Pulse: leave self-refresh |
| row_o | output | 12 | Row the next refresh targets |

## Verification
The timer can earn a credit in the very cycle the controller accepts one. The block must then leave the owed count as it is, rather than losing or doubling a credit. This is forced by an interval of 1 with ready held high, so both happen on every edge. It also arises by chance under random intervals and ready patterns. It is judged by checking that `req_valid_o` never drops and that `row_o` advances once per edge. A second collision, a credit arriving at the saturation limit, is provoked by a long stall. It is judged by counting exactly eight row steps afterwards.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } sr_mode_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval_i,
  input  logic          run_i,
  input  logic          restart_i,
  output logic          tick_o
);
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] last;

  // an interval of zero behaves as one
  assign last   = (interval_i == '0) ? '0 : interval_i - IW'(1);
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tick_o ? '0 : cnt_q + IW'(1);
  end

  // R7: timer frozen in self-refresh
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int MAX_OWED = 8,
  localparam int CW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ack_i,
  input  logic          clear_i,
  input  logic          load_one_i,
  output logic [CW-1:0] owed_o
);
  logic [CW-1:0] owed_q;
  logic [CW-1:0] owed_d;

  always_comb begin
    owed_d = owed_q;
    unique case ({tick_i, ack_i})
      2'b10:   if (owed_q != CW'(MAX_OWED)) owed_d = owed_q + CW'(1);
      2'b01:   owed_d = owed_q - CW'(1);
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          owed_q <= '0;
    else if (clear_i)    owed_q <= '0;
    else if (load_one_i) owed_q <= CW'(1);
    else                 owed_q <= owed_d;
  end

  assign owed_o = owed_q;

  // R5: never above the limit
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= CW'(MAX_OWED));
  // R4: credit and accept in one cycle cancel
  p_tick_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ack_i && !clear_i && !load_one_i) |=> $stable(owed_q));
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [RW-1:0] row_o
);
  logic [RW-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (step_i) row_q <= row_q + RW'(1);
  end

  assign row_o = row_q;

  // R6: one step per accept, wrapping
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (row_q == $past(row_q) + RW'(1)));
  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(row_q));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int IW       = 12,
  parameter int ROWS     = 4096,
  parameter int MAX_OWED = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  input  logic          sr_enter_i,
  input  logic          sr_exit_i,
  output logic [RW-1:0] row_o
);
  import refresh_pkg::*;

  sr_mode_e      mode_q;
  logic          enter_ok, exit_ok, tick, accept;
  logic [CW-1:0] owed;

  assign enter_ok = (mode_q == MODE_RUN)  && sr_enter_i;
  assign exit_ok  = (mode_q == MODE_SELF) && sr_exit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_RUN;
    else if (enter_ok) mode_q <= MODE_SELF;
    else if (exit_ok)  mode_q <= MODE_RUN;
  end

  refresh_timer #(.IW(IW)) timer_i (
    .clk(clk), .rst_n(rst_n), .interval_i(interval_i),
    .run_i(mode_q == MODE_RUN), .restart_i(exit_ok), .tick_o(tick)
  );

  refresh_debt #(.MAX_OWED(MAX_OWED)) debt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ack_i(accept),
    .clear_i(enter_ok), .load_one_i(exit_ok), .owed_o(owed)
  );

  refresh_row_ctr #(.RW(RW)) row_i (
    .clk(clk), .rst_n(rst_n), .step_i(accept), .row_o(row_o)
  );

  assign req_valid_o = (owed != '0) && (mode_q == MODE_RUN);
  assign accept      = req_valid_o && req_ready_i;

  // R3: request held until accepted
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !sr_enter_i) |=> req_valid_o);
  // R8: request right after leaving self-refresh
  p_exit_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ok |=> req_valid_o);
  // R7: entering drops the request
  p_enter_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ok |=> !req_valid_o);
endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
  localparam int IW = 12;
  localparam int RW = 12;
  localparam int MAXO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] interval_i = 12'd5;
  logic          req_ready_i = 1'b0;
  logic          sr_enter_i = 1'b0;
  logic          sr_exit_i = 1'b0;
  logic          req_valid_o;
  logic [RW-1:0] row_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refresh_sched dut_i (
    .clk(clk), .rst_n(rst_n), .interval_i(interval_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .sr_enter_i(sr_enter_i), .sr_exit_i(sr_exit_i), .row_o(row_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  int  m_cnt = 0, m_owed = 0, m_row = 0;
  bit  m_self = 0;

  function automatic int last_of(input int iv);
    return (iv == 0) ? 0 : iv - 1;
  endfunction
  function automatic bit m_valid();
    return (m_owed != 0) && !m_self;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_owed <= 0; m_row <= 0; m_self <= 0;
    end else begin
      bit tk, acc, en, ex;
      int o;
      tk  = !m_self && (m_cnt >= last_of(int'(interval_i)));
      acc = m_valid() && req_ready_i;
      en  = !m_self && sr_enter_i;
      ex  = m_self && sr_exit_i;
      if (acc) m_row <= (m_row + 1) % 4096;
      if (ex) m_cnt <= 0;
      else if (!m_self) m_cnt <= tk ? 0 : m_cnt + 1;
      o = m_owed + (tk ? 1 : 0) - (acc ? 1 : 0);
      if (o > MAXO) o = MAXO;
      if (en) m_owed <= 0;
      else if (ex) m_owed <= 1;
      else m_owed <= o;
      if (en) m_self <= 1;
      else if (ex) m_self <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_valid_o == m_valid(), "R2 R3 R4 R7 R8 R9 request", req_valid_o, m_valid());
      check(int'(row_o) == m_row, "R6 row", row_o, m_row);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0;
    void'($urandom(32'd2024));
    cyc(3);
    check(req_valid_o == 1'b0, "R1 reset valid", req_valid_o, 0);
    check(row_o == '0, "R1 reset row", row_o, 0);
    rst_n = 1'b1;
    // R2: first request after exactly 5 edges
    cyc(4);
    check(req_valid_o == 1'b0, "R2 before interval", req_valid_o, 0);
    cyc(1);
    check(req_valid_o == 1'b1, "R2 at interval", req_valid_o, 1);
    // R3 and R5: long stall saturates the debt
    cyc(45);
    check(req_valid_o == 1'b1, "R3 held", req_valid_o, 1);
    interval_i = 12'd4095;
    r0 = int'(row_o);
    req_ready_i = 1'b1;
    cyc(20);
    check(((int'(row_o) - r0 + 4096) % 4096) == MAXO, "R5 saturated accepts",
          (int'(row_o) - r0 + 4096) % 4096, MAXO);
    // R7, R8, R9: self-refresh
    req_ready_i = 1'b0; interval_i = 12'd3;
    cyc(6);
    sr_enter_i = 1'b1; cyc(1); sr_enter_i = 1'b0;
    check(req_valid_o == 1'b0, "R7 enter drops request", req_valid_o, 0);
    r0 = int'(row_o);
    req_ready_i = 1'b1;
    cyc(30);
    check(int'(row_o) == r0, "R7 ready ignored in self-refresh", row_o, r0);
    sr_enter_i = 1'b1; cyc(1); sr_enter_i = 1'b0;
    check(req_valid_o == 1'b0, "R9 enter ignored", req_valid_o, 0);
    req_ready_i = 1'b0;
    sr_exit_i = 1'b1; cyc(1); sr_exit_i = 1'b0;
    check(req_valid_o == 1'b1, "R8 exit raises request", req_valid_o, 1);
    sr_exit_i = 1'b1; cyc(1); sr_exit_i = 1'b0;
    check(req_valid_o == 1'b1, "R9 exit ignored while running", req_valid_o, 1);
    // R4 and R6: credit and accept every edge, row wraps
    interval_i = 12'd1; req_ready_i = 1'b1;
    cyc(2);
    r0 = int'(row_o);
    cyc(4100);
    check(req_valid_o == 1'b1, "R4 continuous request", req_valid_o, 1);
    check(int'(row_o) == (r0 + 4100) % 4096, "R6 wrap", row_o, (r0 + 4100) % 4096);
    // R2: lowering the interval below the count
    interval_i = 12'd200; req_ready_i = 1'b0;
    cyc(60);
    interval_i = 12'd10;
    cyc(3);
    // random phase checked by the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) interval_i = IW'($urandom_range(0, 12));
      req_ready_i = ($urandom_range(0, 3) != 0);
      sr_enter_i  = ($urandom_range(0, 150) == 0);
      sr_exit_i   = ($urandom_range(0, 40) == 0);
      cyc(1);
    end
    sr_enter_i = 1'b0; sr_exit_i = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule